// File: doc/BRIEF.md
# Compare-Match Timer Status Unit

This block is a small free-running event timer for a microcontroller-class subsystem. An up-counter advances on every cycle in which the count enable is high. Two compare registers watch the count. Each compare hit, and each wrap of the counter from its top value back to zero, raises a sticky request flag. The flags are visible to the CPU in a combined control/status word. A single waveform pin is driven from the two compare hits, under a 4-bit action selector held in the same word.

The CPU reaches the counter, the two compare registers and the control/status word through a minimal register bus. The bus has a 2-bit address, a write strobe, a read strobe, write data, and read data that is valid in the same cycle. A flag can be cleared by the CPU only through a handshake: the CPU first reads the status word and sees the flag as 1, then writes 0 to that flag. A transfer controller can also retire either compare flag with a one-cycle acknowledge pulse.

Address map: 0 counter, 1 compare A, 2 compare B, 3 control/status. Status word: bit 7 compare-B flag, bit 6 compare-A flag, bit 5 wrap flag, bit 4 constant 1, bits 3:2 action on a compare-B hit, bits 1:0 action on a compare-A hit.

Top module: `cmt_status_unit`

## Requirements
- R1: After reset the counter reads 0x00, both compare registers read 0xFF, the status word reads 0x10, and irq_cma, irq_cmb, irq_ovf, cmp_out and out_en are all 0.
- R2: A write to address 0 loads the counter and takes priority over counting. Otherwise the counter increments by one, modulo 256, on each cycle with cnt_en high, and holds when cnt_en is low.
- R3: A "counting cycle" is a cycle with cnt_en high and no write to address 0. A counting cycle in which the counter is 0xFF sets the wrap flag (status bit 5, irq_ovf) at that clock edge.
- R4: A counting cycle in which the counter equals compare A sets flag A (status bit 6, irq_cma). A counting cycle in which the counter equals compare B sets flag B (status bit 7, irq_cmb).
- R5: A write to address 3 that carries 0 in a flag bit clears that flag only if a status read since the previous status write returned the flag as 1. Writing 1 in a flag bit leaves the flag unchanged. Every status write disarms all flags.
- R6: A flag that read as 0 and set afterwards is not cleared by the next status write of 0.
- R7: A pulse on ack_a clears flag A at that clock edge, and a pulse on ack_b clears flag B.
- R8: When a flag's set condition and any clear condition occur in the same cycle, the flag ends set.
- R9: Bits 1:0 select the pin action on a compare-A hit and bits 3:2 the action on a compare-B hit, with 00 none, 01 drive low, 10 drive high, 11 toggle. The pin changes at the edge that ends the counting cycle.
- R10: When A and B hit in the same counting cycle and B's action is not 00, only B's action is applied.
- R11: While bits 3:0 are all 0, out_en and cmp_out are 0. The internal pin level is kept and appears again on cmp_out once any select bit is set.
- R12: A status read returns the three flags in bits 7:5, 1 in bit 4, and the last written bits 3:0.
- R13: Reads of addresses 0, 1 and 2 return the current counter, compare A and compare B values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Count enable |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the flag handshake on address 3) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| ack_a | input | 1 | Transfer controller acknowledge for flag A |
| ack_b | input | 1 | Transfer controller acknowledge for flag B |
| irq_cma | output | 1 | Flag A request |
| irq_cmb | output | 1 | Flag B request |
| irq_ovf | output | 1 | Wrap flag request |
| cmp_out | output | 1 | Waveform pin |
| out_en | output | 1 | Pin enable (any select bit set) |

## Verification
Two collisions matter most. The first is a flag's set event landing in the same cycle as its clear, either from an armed CPU write of 0 or from an acknowledge pulse. The bench provokes it by loading the counter with the compare value and issuing the clear in that counting cycle, and it expects the flag to stay set. The second is compare A and compare B hitting together with opposing pin actions. The bench provokes it with equal compare values and two select patterns, and it expects the pin to take B's action each time. A behavioural reference model is compared on every clock, including through a long stretch of random traffic.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_CMPA  = 2'd1,
    REG_CMPB  = 2'd2,
    REG_CTRL  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pin_act_e;

  // flag indices, also their order upward from the flag field base
  localparam int FLG_WRAP  = 0;
  localparam int FLG_A     = 1;
  localparam int FLG_B     = 2;
  localparam int NUM_FLAGS = 3;

  localparam int SEL_W        = 4;
  localparam int STAT_ONE_BIT = SEL_W;
  localparam int STAT_FLG_LSB = SEL_W + 1;
  localparam int STAT_W       = STAT_FLG_LSB + NUM_FLAGS;

  function automatic logic apply_act(input pin_act_e act, input logic lvl);
    case (act)
      ACT_LOW:    apply_act = 1'b0;
      ACT_HIGH:   apply_act = 1'b1;
      ACT_TOGGLE: apply_act = ~lvl;
      default:    apply_act = lvl;
    endcase
  endfunction

endpackage

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic [W-1:0] cnt,
  output logic         hit_a,
  output logic         hit_b,
  output logic         wrap
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         step;

  assign step = en & ~load;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (en) begin
      cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load | en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt   = cnt_q;
  assign hit_a = step & (cnt_q == cmp_a);
  assign hit_b = step & (cnt_q == cmp_b);
  assign wrap  = step & (cnt_q == TOP);

endmodule

// File: rtl/cmt_flags.sv
module cmt_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] ack,
  input  logic         rd_stb,
  input  logic         wr_stb,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] flag
);

  logic [N-1:0] flag_q, flag_d;
  logic [N-1:0] arm_q, arm_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic clr;

    // armed write of zero, or an acknowledge, retires the flag
    assign clr = ack[i] | (wr_stb & ~wr_bits[i] & arm_q[i]);

    always_comb begin
      flag_d[i] = set[i] | (flag_q[i] & ~clr);
      if (wr_stb) begin
        arm_d[i] = 1'b0;
      end else if (rd_stb) begin
        arm_d[i] = flag_q[i];
      end else begin
        arm_d[i] = arm_q[i] & flag_q[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else begin
        flag_q[i] <= flag_d[i];
        arm_q[i]  <= arm_d[i];
      end
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/cmt_outpin.sv
module cmt_outpin
  import cmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             hit_a,
  input  logic             hit_b,
  output logic             pin,
  output logic             pin_en
);

  pin_act_e act_a, act_b;
  logic     lvl_q, lvl_d;
  logic     upd;

  assign act_a = pin_act_e'(sel[1:0]);
  assign act_b = pin_act_e'(sel[3:2]);

  always_comb begin
    lvl_d = lvl_q;
    upd   = 1'b0;
    if (hit_b && act_b != ACT_NONE) begin
      lvl_d = apply_act(act_b, lvl_q);
      upd   = 1'b1;
    end else if (hit_a && act_a != ACT_NONE) begin
      lvl_d = apply_act(act_a, lvl_q);
      upd   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (upd) begin
      lvl_q <= lvl_d;
    end
  end

  assign pin_en = |sel;
  assign pin    = pin_en & lvl_q;

endmodule

// File: rtl/cmt_status_unit.sv
module cmt_status_unit
  import cmt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ack_a,
  input  logic              ack_b,
  output logic              irq_cma,
  output logic              irq_cmb,
  output logic              irq_ovf,
  output logic              cmp_out,
  output logic              out_en
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  // bus decode
  reg_sel_e sel_reg;
  logic     wr_cnt, wr_cmpa, wr_cmpb, wr_ctrl, rd_ctrl;

  assign sel_reg = reg_sel_e'(bus_addr);
  assign wr_cnt  = bus_wr & (sel_reg == REG_COUNT);
  assign wr_cmpa = bus_wr & (sel_reg == REG_CMPA);
  assign wr_cmpb = bus_wr & (sel_reg == REG_CMPB);
  assign wr_ctrl = bus_wr & (sel_reg == REG_CTRL);
  assign rd_ctrl = bus_rd & (sel_reg == REG_CTRL);

  // compare and select registers
  logic [DATA_W-1:0] cmp_a_val, cmp_a_d;
  logic [DATA_W-1:0] cmp_b_val, cmp_b_d;
  logic [SEL_W-1:0]  sel_val, sel_d;

  always_comb begin
    cmp_a_d = wr_cmpa ? bus_wdata : cmp_a_val;
    cmp_b_d = wr_cmpb ? bus_wdata : cmp_b_val;
    sel_d   = wr_ctrl ? bus_wdata[SEL_W-1:0] : sel_val;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmp_a_val <= '1;
      cmp_b_val <= '1;
      sel_val   <= '0;
    end else begin
      if (wr_cmpa) cmp_a_val <= cmp_a_d;
      if (wr_cmpb) cmp_b_val <= cmp_b_d;
      if (wr_ctrl) sel_val   <= sel_d;
    end
  end

  // counter
  logic [DATA_W-1:0] cnt_val;
  logic              hit_a, hit_b, wrap;

  cmt_counter #(.W(DATA_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (cnt_en),
    .load     (wr_cnt),
    .load_val (bus_wdata),
    .cmp_a    (cmp_a_val),
    .cmp_b    (cmp_b_val),
    .cnt      (cnt_val),
    .hit_a    (hit_a),
    .hit_b    (hit_b),
    .wrap     (wrap)
  );

  // flags
  logic [NUM_FLAGS-1:0] flg_set, flg_ack, flg_val;

  always_comb begin
    flg_set           = '0;
    flg_set[FLG_WRAP] = wrap;
    flg_set[FLG_A]    = hit_a;
    flg_set[FLG_B]    = hit_b;
    flg_ack           = '0;
    flg_ack[FLG_A]    = ack_a;
    flg_ack[FLG_B]    = ack_b;
  end

  cmt_flags #(.N(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set     (flg_set),
    .ack     (flg_ack),
    .rd_stb  (rd_ctrl),
    .wr_stb  (wr_ctrl),
    .wr_bits (bus_wdata[STAT_FLG_LSB +: NUM_FLAGS]),
    .flag    (flg_val)
  );

  // output pin
  cmt_outpin u_outpin (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sel    (sel_val),
    .hit_a  (hit_a),
    .hit_b  (hit_b),
    .pin    (cmp_out),
    .pin_en (out_en)
  );

  // read mux
  logic [STAT_W-1:0] stat_word;

  assign stat_word = {flg_val, 1'b1, sel_val};

  always_comb begin
    case (sel_reg)
      REG_COUNT: bus_rdata = cnt_val;
      REG_CMPA:  bus_rdata = cmp_a_val;
      REG_CMPB:  bus_rdata = cmp_b_val;
      default:   bus_rdata = DATA_W'(stat_word);
    endcase
  end

  assign irq_cma = flg_val[FLG_A];
  assign irq_cmb = flg_val[FLG_B];
  assign irq_ovf = flg_val[FLG_WRAP];

endmodule

// File: rtl/cmt_status_unit_chk.sv
module cmt_status_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic [1:0]   bus_addr,
  input logic         bus_wr,
  input logic         bus_rd,
  input logic [W-1:0] bus_rdata,
  input logic         ack_a,
  input logic         irq_cma,
  input logic         irq_ovf,
  input logic         cmp_out,
  input logic         out_en,
  input logic [W-1:0] cnt_val,
  input logic [W-1:0] cmp_a_val
);

  logic step;
  assign step = cnt_en & ~(bus_wr & (bus_addr == 2'd0));

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_val == W'($past(cnt_val) + 1'b1)));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !bus_wr) |=> $stable(cnt_val));

  a_r3_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_val == {W{1'b1}}) |=> irq_ovf);

  a_r4_match_a_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_val == cmp_a_val) |=> irq_cma);

  a_r5_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovf && !(bus_wr && bus_addr == 2'd3)) |=> irq_ovf);

  a_r7_ack_a_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_a && !(step && cnt_val == cmp_a_val)) |=> !irq_cma);

  a_r11_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !cmp_out);

  a_r12_fixed_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd3) |-> bus_rdata[4]);

endmodule

bind cmt_status_unit cmt_status_unit_chk #(.W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cnt_en    (cnt_en),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .ack_a     (ack_a),
  .irq_cma   (irq_cma),
  .irq_ovf   (irq_ovf),
  .cmp_out   (cmp_out),
  .out_en    (out_en),
  .cnt_val   (cnt_val),
  .cmp_a_val (cmp_a_val)
);

// File: tb/cmt_status_unit_test.sv
`timescale 1ns/1ps
module cmt_status_unit_test;

  logic       clk;
  logic       rst_n;
  logic       cnt_en;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       ack_a, ack_b;
  logic       irq_cma, irq_cmb, irq_ovf, cmp_out, out_en;

  cmt_status_unit uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ack_a(ack_a), .ack_b(ack_b),
    .irq_cma(irq_cma), .irq_cmb(irq_cmb), .irq_ovf(irq_ovf),
    .cmp_out(cmp_out), .out_en(out_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int last_rd;

  // reference model state
  int m_cnt, m_ca, m_cb, m_sel;
  bit m_fa, m_fb, m_fo, m_arm_a, m_arm_b, m_arm_o, m_pin;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_rd(input int a);
    case (a)
      0: return m_cnt;
      1: return m_ca;
      2: return m_cb;
      default: return (int'(m_fb) << 7) | (int'(m_fa) << 6) | (int'(m_fo) << 5) | 16 | m_sel;
    endcase
  endfunction

  function automatic bit act(input int code, input bit lvl);
    if (code == 1) return 1'b0;
    if (code == 2) return 1'b1;
    if (code == 3) return ~lvl;
    return lvl;
  endfunction

  task automatic model_step(input int a, input int w, input int r, input int d,
                            input int e, input int ka, input int kb);
    bit stepping, ha, hb, ho, ctl_w, ctl_r;
    int sa, sb;
    stepping = (e != 0) && !(w != 0 && a == 0);
    ha = stepping && (m_cnt == m_ca);
    hb = stepping && (m_cnt == m_cb);
    ho = stepping && (m_cnt == 255);
    ctl_w = (w != 0) && a == 3;
    ctl_r = (r != 0) && a == 3;
    sa = m_sel % 4;
    sb = m_sel / 4;
    // pin: B has priority when its action is active
    if (hb && sb != 0)      m_pin = act(sb, m_pin);
    else if (ha && sa != 0) m_pin = act(sa, m_pin);
    // handshake arms, from old flags
    if (ctl_w) begin
      if (m_arm_a && d[6] == 0) m_fa = 0;
      if (m_arm_b && d[7] == 0) m_fb = 0;
      if (m_arm_o && d[5] == 0) m_fo = 0;
    end
    if (ka != 0) m_fa = 0;
    if (kb != 0) m_fb = 0;
    if (ctl_w) begin
      m_arm_a = 0; m_arm_b = 0; m_arm_o = 0;
    end else if (ctl_r) begin
      m_arm_a = model_rd(3) >> 6 & 1 ? 1'b1 : 1'b0;
      m_arm_a = (m_fa == 1 && (m_arm_a || 1)) ? m_fa : 1'b0;
      m_arm_b = m_fb;
      m_arm_o = m_fo;
    end
    if (ha) m_fa = 1;
    if (hb) m_fb = 1;
    if (ho) m_fo = 1;
    if (!ctl_w && !ctl_r) begin
      m_arm_a = m_arm_a & m_fa;
      m_arm_b = m_arm_b & m_fb;
      m_arm_o = m_arm_o & m_fo;
    end
    if (ctl_w) m_sel = d % 16;
    if (w != 0 && a == 1) m_ca = d;
    if (w != 0 && a == 2) m_cb = d;
    if (w != 0 && a == 0) m_cnt = d;
    else if (e != 0)      m_cnt = (m_cnt + 1) % 256;
  endtask

  task automatic cyc(input int a, input int w, input int r, input int d,
                     input int e, input int ka, input int kb);
    bus_addr = 2'(a); bus_wr = w[0]; bus_rd = r[0]; bus_wdata = 8'(d);
    cnt_en = e[0]; ack_a = ka[0]; ack_b = kb[0];
    #1;
    if (r != 0) begin
      last_rd = int'(bus_rdata);
      chk(a == 3 ? "R12 status read" : "R13 register read", last_rd, model_rd(a));
    end
    @(posedge clk);
    model_step(a, w, r, d, e, ka, kb);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; ack_a = 1'b0; ack_b = 1'b0;
    chk("R4 irq_cma", int'(irq_cma), int'(m_fa));
    chk("R4 irq_cmb", int'(irq_cmb), int'(m_fb));
    chk("R3 irq_ovf", int'(irq_ovf), int'(m_fo));
    chk("R11 out_en", int'(out_en), int'(m_sel != 0));
    chk("R9 cmp_out", int'(cmp_out), int'(m_sel != 0 && m_pin));
  endtask

  task automatic wr(input int a, input int d, input int e);
    cyc(a, 1, 0, d, e, 0, 0);
  endtask

  task automatic rd(input int a, input int e);
    cyc(a, 0, 1, 0, e, 0, 0);
  endtask

  task automatic idle(input int n, input int e);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, e, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; bus_addr = 2'd0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = 8'd0; ack_a = 1'b0; ack_b = 1'b0;
    m_cnt = 0; m_ca = 255; m_cb = 255; m_sel = 0;
    m_fa = 0; m_fb = 0; m_fo = 0; m_arm_a = 0; m_arm_b = 0; m_arm_o = 0; m_pin = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(0, 0); chk("R1 counter", last_rd, 'h00);
    rd(1, 0); chk("R1 compare A", last_rd, 'hFF);
    rd(2, 0); chk("R1 compare B", last_rd, 'hFF);
    rd(3, 0); chk("R1 status", last_rd, 'h10);
    chk("R1 outputs", int'({irq_cma, irq_cmb, irq_ovf, cmp_out, out_en}), 0);

    // R9 set on A at 5, clear on B at 9; R2 counting
    wr(1, 5, 0); wr(2, 9, 0); wr(3, 'h06, 0); wr(0, 0, 0);
    idle(7, 1);
    chk("R9 drive high on A", int'(cmp_out), 1);
    idle(5, 1);
    chk("R9 drive low on B", int'(cmp_out), 0);
    rd(0, 0); chk("R2 count value", last_rd, 12);
    chk("R4 both flags", int'({irq_cmb, irq_cma}), 3);

    // R5 handshake
    wr(3, 'h06, 0);
    chk("R5 unarmed write keeps A", int'(irq_cma), 1);
    rd(3, 0); chk("R12 status layout", last_rd, 'hD6);
    wr(3, 'h46, 0);
    chk("R5 armed zero clears B", int'(irq_cmb), 0);
    chk("R5 one leaves A", int'(irq_cma), 1);
    wr(3, 'h06, 0);
    chk("R5 write disarms", int'(irq_cma), 1);
    rd(3, 0); wr(3, 'h06, 0);
    chk("R5 clear A", int'(irq_cma), 0);

    // R6 flag set after read survives
    rd(3, 0);
    wr(0, 4, 0); idle(2, 1);
    wr(3, 'h06, 0);
    chk("R6 late flag kept", int'(irq_cma), 1);

    // R7 acknowledges
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R7 ack_a", int'(irq_cma), 0);
    wr(0, 8, 0); idle(2, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R7 ack_b", int'(irq_cmb), 0);

    // R8 set wins over ack and over armed write
    wr(0, 5, 0);
    cyc(0, 0, 0, 0, 1, 1, 0);
    chk("R8 set beats ack", int'(irq_cma), 1);
    rd(3, 0); wr(0, 5, 0);
    cyc(3, 1, 0, 'h06, 1, 0, 0);
    chk("R8 set beats write", int'(irq_cma), 1);

    // R3 wrap
    wr(0, 'hFE, 0); idle(3, 1);
    chk("R3 wrap flag", int'(irq_ovf), 1);
    rd(3, 0); wr(3, 'h06, 0);
    chk("R5 wrap cleared", int'(irq_ovf), 0);

    // R10 B priority
    wr(1, 20, 0); wr(2, 20, 0); wr(3, 'h02, 0); wr(0, 20, 0); idle(1, 1);
    chk("R9 A alone high", int'(cmp_out), 1);
    wr(3, 'h06, 0); wr(0, 20, 0); idle(1, 1);
    chk("R10 B low wins", int'(cmp_out), 0);
    wr(3, 'h09, 0); wr(0, 20, 0); idle(1, 1);
    chk("R10 B high wins", int'(cmp_out), 1);

    // R11 disable keeps level
    wr(3, 'h00, 0);
    chk("R11 disabled pin", int'({cmp_out, out_en}), 0);
    wr(3, 'h04, 0);
    chk("R11 level restored", int'({cmp_out, out_en}), 3);

    // R9 toggle
    wr(1, 30, 0); wr(2, 32, 0); wr(3, 'h0F, 0); wr(0, 28, 0);
    idle(3, 1);
    chk("R9 toggle first", int'(cmp_out), 0);
    idle(3, 1);
    chk("R9 toggle second", int'(cmp_out), 1);

    // random traffic against the model (all requirements)
    for (int i = 0; i < 600; i++) begin
      int a, w, r;
      a = int'($urandom % 4);
      w = int'($urandom % 4 == 0);
      r = int'($urandom % 3 == 0);
      cyc(a, w, r, int'($urandom % 256), int'($urandom % 8 != 0),
          int'($urandom % 7 == 0), int'($urandom % 7 == 0));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule